// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

This block guards a system against runaway software. Once software has set its enable bit and then completed a two-write feed handshake, a 32-bit counter loaded from a reload register counts down once every four clocks. If software lets the count run out, or botches the handshake while the watchdog is running, the block raises either an interrupt or a one-cycle system reset request, depending on the mode chosen before the last good feed.

The enable and reset-mode bits can be set by software but never cleared by it. Only the external reset or the watchdog's own reset event returns them to zero. A timeout flag survives the watchdog's own reset, so software can tell after restart that the watchdog fired. A freeze input stops the countdown, for example while a debugger holds the processor.

Top module: `wdt_feed_guard`

## Requirements
- R1: After reset the reload register and the count both read 256. A write to the reload register stores the written value, or 256 if the value is below 256.
- R2: Mode bit 0 (enable) and bit 1 (reset mode) are set by writing 1. Writing 0 to them has no effect. Only the external reset or a watchdog reset event clears them.
- R3: The countdown is idle until a valid feed happens with the enable bit set. A valid feed is a write of low byte 0xAA to the feed address followed, on the very next register write, by a write of low byte 0x55 to the feed address. Every valid feed loads the count with the reload value and restarts the divide-by-four phase.
- R4: While running and not frozen, the count decrements once every four clocks. A count loaded with N by a feed whose second write is sampled at clock edge E reaches 0 at edge E+4N. The count then stays at 0.
- R5: In interrupt mode (reset mode not active), the interrupt output rises at the edge where the count reaches 0. It stays high until software clears the timeout flag.
- R6: In reset mode, an event drives the reset output high for exactly one cycle. In the same step it clears the enable, reset-mode and running bits and returns the reload and count to 256.
- R7: While running, a broken feed is treated as an event like expiry. A broken feed is a first write to the feed address whose low byte is not 0xAA, a second write whose low byte is not 0x55, or a write to any other address between the two feed writes.
- R8: While the watchdog is not running, a broken feed causes no event.
- R9: Mode bit 2 (timeout flag) is set by every event. A mode write with bit 2 at 0 clears it, and a write with bit 2 at 1 leaves it unchanged. The flag survives the watchdog reset and is cleared by the external reset.
- R10: While the freeze input is high, the count does not change.
- R11: Register map: address 0 is mode (bit 0 enable, bit 1 reset mode, bit 2 timeout flag, bit 3 running read-only), address 1 is reload, address 2 is feed (reads 0), and address 3 is the current count (read-only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low external reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 32 | Register read data (combinational) |
| freeze | input | 1 | Halts the countdown while high |
| wdIrq | output | 1 | Watchdog interrupt, level |
| wdResetOut | output | 1 | One-cycle system reset request |

## Verification
The bench measures the exact edge on which a minimum-length count expires. A design with an off-by-one in the divide-by-four phase, or in the zero detection, would raise the interrupt or reset pulse one or more clocks early or late.

It tries to clear the enable bit and to set the timeout flag by plain writes. A design lacking stickiness would stop the watchdog, or would report a false timeout.

It breaks the handshake in each of three ways: a wrong first key, a wrong second key, and a foreign write in between. It does this both while running and while idle. A design that ignored one form of breakage, or that punished feeds before the watchdog was running, would miss or invent an event.

It also checks the clamp on small reload values, the hold under freeze, and the flag surviving a watchdog reset but not an external one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_FEED   = 2'd2;
  localparam logic [1:0] ADDR_COUNT  = 2'd3;

  typedef struct packed {
    logic feedOk;    // valid handshake completed: load count
    logic countEn;   // running and not frozen
    logic wdClear;   // watchdog reset event: restore defaults
    logic reloadWr;  // software write to reload register
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'hAA,
  parameter logic [7:0] KEY_SECOND = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrByte,
  input  logic       freeze,
  input  logic       expire,
  output wdtStrobe_t strb,
  output logic       enReq,
  output logic       rstReq,
  output logic       running,
  output logic       flag,
  output logic       wdIrq,
  output logic       wdResetOut
);
  logic armed;
  logic rstEff;
  logic feedWr, modeWr, goodFeed, badSeq, badFeed, evt, wdRstNow;

  always_comb begin
    feedWr   = wrEn && (wrAddr == ADDR_FEED);
    modeWr   = wrEn && (wrAddr == ADDR_MODE);
    goodFeed = feedWr && armed && (wrByte == KEY_SECOND);
    badSeq   = armed ? (wrEn && !goodFeed) : (feedWr && (wrByte != KEY_FIRST));
    badFeed  = badSeq && running;
    evt      = badFeed || expire;
    wdRstNow = evt && rstEff;

    strb.feedOk   = goodFeed && !wdRstNow;
    strb.countEn  = running && !freeze;
    strb.wdClear  = wdRstNow;
    strb.reloadWr = wrEn && (wrAddr == ADDR_RELOAD) && !wdRstNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      enReq      <= 1'b0;
      rstReq     <= 1'b0;
      running    <= 1'b0;
      rstEff     <= 1'b0;
      wdResetOut <= 1'b0;
    end else begin
      wdResetOut <= wdRstNow;
      if (wdRstNow) begin
        armed   <= 1'b0;
        enReq   <= 1'b0;
        rstReq  <= 1'b0;
        running <= 1'b0;
        rstEff  <= 1'b0;
      end else begin
        armed <= armed ? !wrEn : (feedWr && (wrByte == KEY_FIRST));
        if (modeWr && wrByte[0]) enReq  <= 1'b1;
        if (modeWr && wrByte[1]) rstReq <= 1'b1;
        if (goodFeed && enReq) begin
          running <= 1'b1;
          rstEff  <= rstEff | rstReq;
        end
      end
    end
  end

  // Timeout flag and interrupt; the flag is not touched by the watchdog's own reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      wdIrq <= 1'b0;
    end else if (evt) begin
      flag <= 1'b1;
      if (!rstEff) wdIrq <= 1'b1;
    end else if (modeWr && !wrByte[2]) begin
      flag  <= 1'b0;
      wdIrq <= 1'b0;
    end
  end

  assert_sticky_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enReq && !wdRstNow) |=> enReq);

  assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdResetOut |=> !wdResetOut);

  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(evt));

  assert_idle_no_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !flag) |=> !wdResetOut);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int PRESC_DIV  = 4,
  parameter int MIN_RELOAD = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdtStrobe_t       strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);
  localparam int PRESC_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(PRESC_DIV - 1);
  localparam logic [CNT_W-1:0]   MIN_VAL    = CNT_W'(MIN_RELOAD);
  localparam logic [CNT_W-1:0]   ONE        = CNT_W'(1);

  logic [PRESC_W-1:0] presc;
  logic [CNT_W-1:0]   clamped;
  logic               tick;

  always_comb begin
    clamped = (wrData < MIN_VAL) ? MIN_VAL : wrData;
    tick    = strb.countEn && (presc == PRESC_LAST);
    expire  = tick && (count == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc  <= '0;
      count  <= MIN_VAL;
      reload <= MIN_VAL;
    end else if (strb.wdClear) begin
      presc  <= '0;
      count  <= MIN_VAL;
      reload <= MIN_VAL;
    end else begin
      if (strb.reloadWr) reload <= clamped;
      if (strb.feedOk) begin
        presc <= '0;
        count <= reload;
      end else if (strb.countEn) begin
        presc <= (presc == PRESC_LAST) ? '0 : presc + 1'b1;
        if (tick && (count != '0)) count <= count - ONE;
      end
    end
  end

  assert_min_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reload >= MIN_VAL);

  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.countEn && !strb.feedOk && !strb.wdClear) |=> $stable(count));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.countEn && !strb.feedOk && !strb.wdClear) |=>
      ((count == $past(count)) || (count == $past(count) - ONE)));
endmodule

// File: rtl/wdt_feed_guard.sv
module wdt_feed_guard
  import wdt_pkg::*;
#(
  parameter int         CNT_W      = 32,
  parameter int         PRESC_DIV  = 4,
  parameter int         MIN_RELOAD = 256,
  parameter logic [7:0] KEY_FIRST  = 8'hAA,
  parameter logic [7:0] KEY_SECOND = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic             freeze,
  output logic             wdIrq,
  output logic             wdResetOut
);
  wdtStrobe_t       strb;
  logic             enReq, rstReq, running, flag, expire;
  logic [CNT_W-1:0] count, reload;

  wdt_ctrl #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrByte(wrData[7:0]),
    .freeze(freeze), .expire(expire), .strb(strb), .enReq(enReq), .rstReq(rstReq),
    .running(running), .flag(flag), .wdIrq(wdIrq), .wdResetOut(wdResetOut)
  );

  wdt_datapath #(.CNT_W(CNT_W), .PRESC_DIV(PRESC_DIV), .MIN_RELOAD(MIN_RELOAD)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .count(count), .reload(reload), .expire(expire)
  );

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_MODE:   rdData[3:0] = {running, flag, rstReq, enReq};
      ADDR_RELOAD: rdData = reload;
      ADDR_FEED:   rdData = '0;
      ADDR_COUNT:  rdData = count;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: tb/wdt_feed_guard_tb_top.sv
`timescale 1ns/1ps
module wdt_feed_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        freeze = 1'b0;
  logic        wdIrq, wdResetOut;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_feed_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .freeze(freeze),
    .wdIrq(wdIrq), .wdResetOut(wdResetOut)
  );

  // reload write value, expected read-back (clamped to 256)
  localparam logic [63:0] RELOAD_VEC [0:5] = '{
    {32'd0,       32'd256},
    {32'd100,     32'd256},
    {32'd255,     32'd256},
    {32'd256,     32'd256},
    {32'd257,     32'd257},
    {32'h0001_2345, 32'h0001_2345}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [31:0] exp, input string req);
    rdAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h55);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(1);
    // R11 / R1 reset state
    rdChk(2'd0, 32'h0, "R11 mode after reset");
    rdChk(2'd1, 32'd256, "R1 reload after reset");
    rdChk(2'd3, 32'd256, "R1 count after reset");
    rdChk(2'd2, 32'h0, "R11 feed reads zero");
    check("R5 irq after reset", {31'b0, wdIrq}, 32'd0);
    check("R6 reset out after reset", {31'b0, wdResetOut}, 32'd0);

    // R1 clamp table
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, RELOAD_VEC[i][63:32]);
      rdChk(2'd1, RELOAD_VEC[i][31:0], "R1 reload clamp");
    end
    wr(2'd1, 32'd256);

    // R3 enabled but not fed: idle
    wr(2'd0, 32'h1);
    waitCyc(20);
    rdChk(2'd3, 32'd256, "R3 count idle before feed");
    rdChk(2'd0, 32'h1, "R3 not running before feed");
    // R2 sticky enable
    wr(2'd0, 32'h0);
    rdChk(2'd0, 32'h1, "R2 enable survives write of zero");

    // R3/R4/R5 timing
    feed();
    rdChk(2'd3, 32'd256, "R3 count loaded by feed");
    rdChk(2'd0, 32'h9, "R3 running after feed");
    waitCyc(4);
    rdChk(2'd3, 32'd255, "R4 first decrement after four clocks");
    waitCyc(1019);
    rdChk(2'd3, 32'd1, "R4 count one clock before expiry");
    check("R5 irq low before expiry", {31'b0, wdIrq}, 32'd0);
    waitCyc(1);
    rdChk(2'd3, 32'd0, "R4 count zero at expiry");
    check("R5 irq at expiry", {31'b0, wdIrq}, 32'd1);
    rdChk(2'd0, 32'hD, "R9 flag set on expiry");
    waitCyc(10);
    rdChk(2'd3, 32'd0, "R4 count stays zero");
    check("R5 irq held", {31'b0, wdIrq}, 32'd1);

    // R9 flag write semantics
    wr(2'd0, 32'h4);
    rdChk(2'd0, 32'hD, "R9 writing one keeps flag");
    wr(2'd0, 32'h0);
    rdChk(2'd0, 32'h9, "R9 writing zero clears flag, R2 enable kept");
    check("R5 irq cleared with flag", {31'b0, wdIrq}, 32'd0);

    // R10 freeze
    feed();
    @(negedge clk); freeze = 1'b1;
    waitCyc(1);
    rdAddr = 2'd3; #1;
    begin
      logic [31:0] held;
      held = rdData;
      waitCyc(40);
      rdChk(2'd3, held, "R10 count held under freeze");
    end
    freeze = 1'b0;

    // R7 bad second key while running
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h12);
    check("R7 wrong second key raises irq", {31'b0, wdIrq}, 32'd1);
    wr(2'd0, 32'h0);
    feed();
    // R7 foreign write between keys
    wr(2'd2, 32'hAA);
    wr(2'd1, 32'd256);
    check("R7 foreign write raises irq", {31'b0, wdIrq}, 32'd1);
    wr(2'd0, 32'h0);
    // R7 bad first key
    wr(2'd2, 32'h77);
    check("R7 wrong first key raises irq", {31'b0, wdIrq}, 32'd1);
    wr(2'd0, 32'h0);

    // R6 reset mode expiry
    wr(2'd0, 32'h2);
    feed();
    waitCyc(1023);
    check("R6 no pulse before expiry", {31'b0, wdResetOut}, 32'd0);
    waitCyc(1);
    check("R6 pulse at expiry", {31'b0, wdResetOut}, 32'd1);
    check("R6 no irq in reset mode", {31'b0, wdIrq}, 32'd0);
    waitCyc(1);
    check("R6 pulse one cycle", {31'b0, wdResetOut}, 32'd0);
    rdChk(2'd0, 32'h4, "R6 bits cleared, R9 flag survives");
    rdChk(2'd3, 32'd256, "R6 count restored");

    // R8 bad feed while idle
    wr(2'd0, 32'h0);
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h33);
    check("R8 no pulse when idle", {31'b0, wdResetOut}, 32'd0);
    rdChk(2'd0, 32'h0, "R8 no flag when idle");

    // R7 in reset mode
    wr(2'd0, 32'h3);
    feed();
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h00);
    check("R7 bad feed pulses reset", {31'b0, wdResetOut}, 32'd1);
    waitCyc(1);
    rdChk(2'd0, 32'h4, "R9 flag after bad-feed reset");

    // R9 external reset clears flag
    @(negedge clk); rst_n = 1'b0;
    waitCyc(2);
    rst_n = 1'b1;
    waitCyc(1);
    rdChk(2'd0, 32'h0, "R9 external reset clears flag");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule